// File: doc/BRIEF.md
# Cascaded LED Driver Chain Sequencer

This block is the host side of a long daisy chain of serial PWM LED driver devices. The chain is driven over two wires, a serial clock and a serial data line. The serial clock has two jobs at once. It shifts the next frame's packets into the chain, and every rising edge is also a grayscale tick for the frame the devices are showing now. The sequencer therefore has to produce display periods of an exact length. Each period ends with a quiet clock gap long enough for every device to latch its shift register internally.

A single `start` pulse begins the first frame. That frame is a plain data write: one packet per device, the device farthest from the controller first, each packet MSB first. After the write, the clock is held low for the latch gap, `frame_done` pulses, and a settling wait follows. From then on the block repeats one display period without end. The period is a run of PWM-only clocks with the data line low, then the next frame's full data write, then the latch gap and the settling wait. The upper bits of every packet are a fixed control header. The bits below the header are fetched from a frame memory, one cycle after the address is presented. Timing is set by the serial clock half-period in system cycles, by the latch gap in serial periods, and by the settling time in picoseconds, which is rounded up to whole system cycles.

The controller states are ST_IDLE, ST_SHIFT, ST_GAP, ST_SETTLE and ST_PWM. The transitions are:
- ST_IDLE to ST_SHIFT on `start`.
- ST_SHIFT to ST_GAP when the period of the last packet bit ends.
- ST_GAP to ST_SETTLE when the gap count expires, with a `frame_done` pulse.
- ST_SETTLE to ST_PWM when the settling count expires.
- ST_PWM to ST_SHIFT when the last PWM-only period ends.

Reset returns the block to ST_IDLE from any state.

Top module: `led_chain_seq`

## Requirements
- R1: After reset, `sclk`, `sdata` and `frame_done` are 0, and no serial clock edge appears until `start` is pulsed.
- R2: `start` in idle begins a data write at once, with no PWM-only block before it, so the first frame has exactly N_DEV*PKT_W rising edges. `start` has no effect while a sequence is running.
- R3: Packets go out for device N_DEV-1 first and device 0 last, each from packet bit PKT_W-1 down to bit 0. `sdata` changes only while `sclk` is low.
- R4: The top 11 packet bits (PKT_W-1 down to PKT_W-11) are a fixed header. Listed from the MSB they are: command 100101, edge select 1, external clock 1, timing reset on latch 1, repeat 0, blank 0.
- R5: Packet bits below the header come from `mem_rdata`. `mem_addr` = {device index, packet bit index}, with the bit index in the low $clog2(PKT_W) bits and bit 0 as the packet LSB. Data is taken one system cycle after the address.
- R6: After the last data rising edge, `sclk` stays low. `frame_done` is high exactly SCLK_HALF + LATCH_PERIODS*2*SCLK_HALF system cycles after that edge, so the gap is at least LATCH_PERIODS serial periods.
- R7: `frame_done` is a one-cycle pulse, raised once per latch.
- R8: The first rising edge after `frame_done` comes exactly ceil(SETTLE_PS/SYS_PS) + SCLK_HALF system cycles after the `frame_done` cycle.
- R9: After the settling wait, PWM_CLKS rising edges are sent with `sdata` low, followed directly by the next frame's data. Every display period after the first has PWM_CLKS + N_DEV*PKT_W rising edges between consecutive `frame_done` pulses, which is 65536 with the defaults.
- R10: While running, the serial clock is high for SCLK_HALF cycles and low for SCLK_HALF cycles, so rising edges are 2*SCLK_HALF cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the first frame when idle |
| mem_addr | output | $clog2(N_DEV)+$clog2(PKT_W) | Frame memory address {device, bit} |
| mem_rdata | input | 1 | Frame memory bit, valid one cycle after address |
| sclk | output | 1 | Serial clock to the chain |
| sdata | output | 1 | Serial data to the chain |
| frame_done | output | 1 | One-cycle pulse at each latch |

## Verification
Two events share one cycle at the end of the last PWM-only period: the PWM countdown expires, and the first header bit of the new frame is loaded as the clock falls. A second pair shares one cycle at the end of the last data period: the packet counter wraps and the gap countdown is loaded. Both meetings happen in every display period of a multi-frame run. The bench judges them by the rising-edge count between `frame_done` pulses, by the exact data bit captured at every edge across the PWM-to-data seam, and by the measured gap and settling lengths.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_SETTLE,
        ST_PWM
    } seq_state_t;

    localparam int HDR_W = 11;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic logic [HDR_W-1:0] make_header(
        input logic [5:0] cmd,
        input logic       edge_sel,
        input logic       ext_clk,
        input logic       tm_reset,
        input logic       repeat_on,
        input logic       blank
    );
        return {cmd, edge_sel, ext_clk, tm_reset, repeat_on, blank};
    endfunction

    localparam logic [HDR_W-1:0] DEFAULT_HDR =
        make_header(6'b100101, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

endpackage

// File: rtl/lcs_sclk_gen.sv
module lcs_sclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic per_end
);
    localparam int PERIOD = 2 * HALF;
    localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] ph_nxt;

    always_comb begin
        if (!run || ph == PH_LAST) begin
            ph_nxt = '0;
        end else begin
            ph_nxt = ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= '0;
            sclk <= 1'b0;
        end else begin
            ph   <= ph_nxt;
            sclk <= run && (ph_nxt >= PH_HIGH);
        end
    end

    assign per_end = run && (ph == PH_LAST);

endmodule

// File: rtl/lcs_bit_index.sv
module lcs_bit_index #(
    parameter int N_DEV = 256,
    parameter int PKT_W = 224,
    parameter int DEV_W = 8,
    parameter int BIT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rewind,
    input  logic             advance,
    output logic [DEV_W-1:0] dev_idx,
    output logic [BIT_W-1:0] bit_idx,
    output logic             last_sent
);
    localparam logic [DEV_W-1:0] DEV_TOP = DEV_W'(N_DEV - 1);
    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(PKT_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_idx   <= DEV_TOP;
            bit_idx   <= BIT_TOP;
            last_sent <= 1'b0;
        end else if (rewind) begin
            dev_idx   <= DEV_TOP;
            bit_idx   <= BIT_TOP;
            last_sent <= 1'b0;
        end else if (advance) begin
            last_sent <= (dev_idx == '0) && (bit_idx == '0);
            if (bit_idx == '0) begin
                bit_idx <= BIT_TOP;
                dev_idx <= dev_idx - 1'b1;
            end else begin
                bit_idx <= bit_idx - 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcs_timer.sv
module lcs_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = en && (cnt == CNT_W'(1));

endmodule

// File: rtl/led_chain_seq.sv
module led_chain_seq
    import led_chain_pkg::*;
#(
    parameter int N_DEV         = 256,
    parameter int PKT_W         = 224,
    parameter int PWM_CLKS      = 8192,
    parameter int SCLK_HALF     = 2,
    parameter int LATCH_PERIODS = 8,
    parameter int SYS_PS        = 20000,
    parameter int SETTLE_PS     = 1340000,
    parameter logic [HDR_W-1:0] HDR_WORD = DEFAULT_HDR,
    localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int BIT_W  = $clog2(PKT_W),
    localparam int ADDR_W = DEV_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rdata,
    output logic              sclk,
    output logic              sdata,
    output logic              frame_done
);
    localparam int PAY_W      = PKT_W - HDR_W;
    localparam int GAP_CYC    = LATCH_PERIODS * 2 * SCLK_HALF;
    localparam int SETTLE_RAW = ceil_div(SETTLE_PS, SYS_PS);
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int MAX_A      = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
    localparam int MAX_CNT    = (MAX_A > PWM_CLKS) ? MAX_A : PWM_CLKS;
    localparam int TMR_W      = $clog2(MAX_CNT + 1);
    localparam logic [PKT_W-1:0] PKT_TMPL = {HDR_WORD, {PAY_W{1'b0}}};

    seq_state_t state, state_nxt;

    logic             run;
    logic             per_end;
    logic             advance;
    logic             rewind;
    logic             last_sent;
    logic [DEV_W-1:0] dev_idx;
    logic [BIT_W-1:0] bit_idx;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_en;
    logic             tmr_done;
    logic             bit_val;
    logic             in_header;

    lcs_sclk_gen #(
        .HALF (SCLK_HALF)
    ) u_sclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sclk    (sclk),
        .per_end (per_end)
    );

    lcs_bit_index #(
        .N_DEV (N_DEV),
        .PKT_W (PKT_W),
        .DEV_W (DEV_W),
        .BIT_W (BIT_W)
    ) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rewind    (rewind),
        .advance   (advance),
        .dev_idx   (dev_idx),
        .bit_idx   (bit_idx),
        .last_sent (last_sent)
    );

    lcs_timer #(
        .CNT_W (TMR_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .en       (tmr_en),
        .done     (tmr_done)
    );

    assign mem_addr  = {dev_idx, bit_idx};
    assign in_header = (bit_idx >= BIT_W'(PAY_W));
    assign bit_val   = in_header ? PKT_TMPL[bit_idx] : mem_rdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and control strobes
    always_comb begin
        state_nxt = state;
        run       = 1'b0;
        advance   = 1'b0;
        rewind    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tmr_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    advance   = 1'b1;
                    state_nxt = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                run = 1'b1;
                if (per_end) begin
                    if (last_sent) begin
                        rewind    = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(GAP_CYC);
                        state_nxt = ST_GAP;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                tmr_en = 1'b1;
                if (tmr_done) begin
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(SETTLE_CYC);
                    state_nxt = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                tmr_en = 1'b1;
                if (tmr_done) begin
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(PWM_CLKS);
                    state_nxt = ST_PWM;
                end
            end
            ST_PWM: begin
                run    = 1'b1;
                tmr_en = per_end;
                if (tmr_done) begin
                    advance   = 1'b1;
                    state_nxt = ST_SHIFT;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata      <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= (state == ST_GAP) && tmr_done;
            if (advance) begin
                sdata <= bit_val;
            end else if (rewind) begin
                sdata <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/led_chain_seq_chk.sv
module led_chain_seq_chk
    import led_chain_pkg::*;
#(
    parameter int HALF       = 2,
    parameter int GAP_CYC    = 32,
    parameter int SETTLE_CYC = 67
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       sdata,
    input logic       frame_done,
    input seq_state_t state
);
    localparam int SAT = 1 << 24;

    logic sclk_d;
    logic armed;
    int   since_rise;
    int   since_done;
    int   hi_cnt;
    logic rise;

    assign rise = sclk && !sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d     <= 1'b0;
            armed      <= 1'b0;
            since_rise <= 0;
            since_done <= 0;
            hi_cnt     <= 0;
        end else begin
            sclk_d     <= sclk;
            hi_cnt     <= sclk ? hi_cnt + 1 : 0;
            since_rise <= rise ? 1 : ((since_rise < SAT) ? since_rise + 1 : since_rise);
            since_done <= frame_done ? 1 : ((since_done < SAT) ? since_done + 1 : since_done);
            if (frame_done) begin
                armed <= 1'b1;
            end else if (rise) begin
                armed <= 1'b0;
            end
        end
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdata));

    a_r6_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (since_rise == HALF + GAP_CYC) && !sclk);

    a_r8_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed) |-> (since_done == SETTLE_CYC + HALF));

    a_r10_high_len: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (hi_cnt < HALF));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sclk && !sdata && !frame_done));

    a_r9_pwm_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM) |-> !sdata);

endmodule

bind led_chain_seq led_chain_seq_chk #(
    .HALF       (SCLK_HALF),
    .GAP_CYC    (GAP_CYC),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .sdata      (sdata),
    .frame_done (frame_done),
    .state      (state)
);

// File: tb/led_chain_seq_tb.sv
`timescale 1ns/1ps
module led_chain_seq_tb;
    localparam int N_DEV     = 3;
    localparam int PKT_W     = 16;
    localparam int PWM_CLKS  = 8;
    localparam int HALF      = 2;
    localparam int LATCH_P   = 8;
    localparam int SYS_PS    = 20000;
    localparam int SETTLE_PS = 90000;
    localparam int DEV_W     = 2;
    localparam int BIT_W     = 4;
    localparam int PAY_W     = PKT_W - 11;
    localparam int DATA_N    = N_DEV * PKT_W;
    localparam int EXP_GAP   = HALF + LATCH_P * 2 * HALF;
    localparam int EXP_SET   = 5 + HALF;
    localparam logic [10:0] EXP_HDR = 11'b100101_1_1_1_0_0;
    localparam int NFR = 4;
    localparam int KEYS [NFR]  = '{1, 2, 5, 0};
    localparam int EDGES [NFR] = '{DATA_N, DATA_N + PWM_CLKS, DATA_N + PWM_CLKS, DATA_N + PWM_CLKS};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DEV_W+BIT_W-1:0] mem_addr;
    logic mem_rdata = 1'b0;
    logic sclk, sdata, frame_done;

    int key = 0;
    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    led_chain_seq #(
        .N_DEV (N_DEV), .PKT_W (PKT_W), .PWM_CLKS (PWM_CLKS),
        .SCLK_HALF (HALF), .LATCH_PERIODS (LATCH_P),
        .SYS_PS (SYS_PS), .SETTLE_PS (SETTLE_PS)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .mem_addr (mem_addr),
        .mem_rdata (mem_rdata), .sclk (sclk), .sdata (sdata), .frame_done (frame_done)
    );

    function automatic logic model(input int k, input int dev, input int b);
        return ((k * 13 + dev * 7 + b * 5) % 3) == 0;
    endfunction

    always @(posedge clk) begin
        mem_rdata <= model(key, int'(mem_addr[BIT_W +: DEV_W]), int'(mem_addr[BIT_W-1:0]));
    end

    // monitor
    logic cap [0:255];
    logic snap [0:255];
    int ncap = 0, snapn = 0, since_rise = 0, since_done = 0;
    int gap_meas = 0, settle_meas = 0, bad_space = 0, unstable = 0, dbl = 0, last_rise = 0, cyc = 0;
    logic armed = 1'b0, run_rise = 1'b0, sclk_p = 1'b0, sdata_p = 1'b0, done_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            ncap = 0; armed = 1'b0; run_rise = 1'b0;
            sclk_p = 1'b0; sdata_p = 1'b0; done_p = 1'b0;
        end else begin
            since_rise++;
            since_done++;
            if (sclk && sdata != sdata_p) unstable++;
            if (sclk && !sclk_p) begin
                if (ncap < 256) cap[ncap] = sdata;
                ncap++;
                if (run_rise && (cyc - last_rise) != 2 * HALF) bad_space++;
                run_rise = 1'b1;
                last_rise = cyc;
                since_rise = 0;
                if (armed) begin
                    settle_meas = since_done;
                    armed = 1'b0;
                end
            end
            if (frame_done) begin
                if (done_p) dbl++;
                for (int i = 0; i < 256; i++) snap[i] = cap[i];
                snapn = ncap;
                gap_meas = since_rise;
                ncap = 0;
                armed = 1'b1;
                run_rise = 1'b0;
                since_done = 0;
            end
            sclk_p = sclk; sdata_p = sdata; done_p = frame_done;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic check_frame(input int fidx, input int k);
        int off, hmis, pmis, zmis;
        off = (fidx == 0) ? 0 : PWM_CLKS;
        hmis = 0; pmis = 0; zmis = 0;
        for (int j = 0; j < off; j++) if (snap[j] !== 1'b0) zmis++;
        for (int j = 0; j < DATA_N; j++) begin
            int dev, b;
            logic e;
            dev = N_DEV - 1 - j / PKT_W;
            b = PKT_W - 1 - j % PKT_W;
            if (b >= PAY_W) begin
                e = EXP_HDR[b - PAY_W];
                if (snap[off + j] !== e) hmis++;
            end else begin
                e = model(k, dev, b);
                if (snap[off + j] !== e) pmis++;
            end
        end
        chk(snapn == EDGES[fidx], "R9", "edges per display period", snapn, EDGES[fidx]);
        chk(zmis == 0, "R9", "PWM-only bits not low", zmis, 0);
        chk(hmis == 0, "R4", "header bit mismatches", hmis, 0);
        chk(pmis == 0, "R5", "payload bit mismatches (R3 order)", pmis, 0);
        chk(gap_meas == EXP_GAP, "R6", "latch gap cycles", gap_meas, EXP_GAP);
    endtask

    initial begin
        key = KEYS[0];
        repeat (5) @(negedge clk);
        chk(sclk == 0 && sdata == 0 && frame_done == 0, "R1", "outputs in reset",
            {sclk, sdata, frame_done}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        #1;
        chk(ncap == 0, "R1", "edges before start", ncap, 0);
        pulse_start();
        for (int f = 0; f < NFR; f++) begin
            @(negedge clk iff frame_done);
            #1;
            if (f + 1 < NFR) key = KEYS[f + 1];
            check_frame(f, KEYS[f]);
            if (f >= 1) chk(settle_meas == EXP_SET, "R8", "settle to first edge", settle_meas, EXP_SET);
            if (f == 0) begin
                chk(snapn == DATA_N, "R2", "first frame has no PWM block", snapn, DATA_N);
                pulse_start();
            end
            if (f == 1) chk(snapn == EDGES[1], "R2", "start while running ignored", snapn, EDGES[1]);
        end
        chk(bad_space == 0, "R10", "edge spacing errors", bad_space, 0);
        chk(unstable == 0, "R3", "sdata changes while sclk high", unstable, 0);
        chk(dbl == 0, "R7", "frame_done wider than one cycle", dbl, 0);
        // reset in the middle of a data write
        repeat (120) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 0 && sdata == 0 && frame_done == 0, "R1", "outputs after mid-run reset",
            {sclk, sdata, frame_done}, 0);
        key = 3;
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        #1;
        chk(ncap == 0, "R1", "edges after reset without start", ncap, 0);
        pulse_start();
        @(negedge clk iff frame_done);
        #1;
        check_frame(0, 3);
        chk(snapn == DATA_N, "R2", "restart frame edges", snapn, DATA_N);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule